// File: doc/BRIEF.md
# Power-Management I/O Window Decoder

This block is the configuration-register slice of a power-management PCI function. It holds two relocatable I/O window bases and an enable bit for each. The first window is 128 bytes and fronts the power-management registers. The second is 16 bytes and fronts an SMBus host controller. Software programs the bases and enables through a byte-enabled 32-bit configuration port that is addressed by dword index. Read data returns combinationally for the index presented.

Two outputs, one per window, are decoded from a 16-bit I/O address. Each output tells the surrounding fabric that the access belongs to that window. A window claims nothing while its enable bit is clear. The registers behind the windows are not part of this block. Apart from a read-only identification dword at index 0, the standard header is not part of it either.

Top module: `pm_iodec`

## Requirements
- R1: After reset the power-management base (byte offset 0x48, index 0x12) and the SMBus base (byte offset 0x90, index 0x24) both read 0x00000001. The control bytes read 0, and both hit outputs are low.
- R2: Any write with a nonzero byte enable to index 0x12 leaves the power-management base holding the merged value ANDed with 0x0000FF80, with bit 0 set to 1.
- R3: Any write with a nonzero byte enable to index 0x24 leaves the SMBus base holding the merged value ANDed with 0x0000FFF0, with bit 0 set to 1.
- R4: Byte enable bit n selects data bits 8n+7..8n. Lanes that are not enabled keep their previous contents, and the masking of R2 and R3 is applied to the merged result.
- R5: The power-management control byte is configuration byte 0x41, which is index 0x10, lane 1. It is stored as all 8 bits and reads back in bits 15..8. Its bit 7 enables the power-management window.
- R6: The SMBus control byte is configuration byte 0xD2, which is index 0x34, lane 2. Only its bits 3..0 are stored, and bits 7..4 read back as 0. Its bit 0 enables the SMBus window.
- R7: pm_hit is high exactly when the power-management enable is set and io_addr[15:7] equals base[15:7].
- R8: smb_hit is high exactly when the SMBus enable is set and io_addr[15:4] equals base[15:4].
- R9: Writes to indices or lanes that hold no register have no effect, and those positions read as 0. This covers lanes 0, 2 and 3 of index 0x10 and lanes 0, 1 and 3 of index 0x34.
- R10: Index 0 reads the constant 0xC0DE0100 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls in the enabled power-management window |
| smb_hit | output | 1 | Address falls in the enabled SMBus window |

## Verification
The hardest case to reach from the ports is a hit at the exact edge of an enabled window, at its first and last byte and one byte outside either end. A random 16-bit address lands in a 16-byte window about once in four thousand tries, so random addresses alone almost never get there. The stimulus therefore builds each probe address from the base that the bench expects. It adds offsets of -1, 0, span-1, span, or a random value inside the span. It does this after random partial-lane writes have moved the bases and flipped the enables.

// File: rtl/pm_iodec.sv
module pm_iodec #(
  parameter int IDX_W        = 6,
  parameter int IO_AW        = 16,
  parameter int PM_SPAN_LG   = 7,
  parameter int SMB_SPAN_LG  = 4,
  parameter int PM_CTL_LANE  = 1,
  parameter int SMB_CTL_LANE = 2,
  parameter int PM_EN_BIT    = 7,
  parameter int SMB_EN_BIT   = 0,
  parameter int SMB_CTL_KEEP = 4,
  parameter logic [IDX_W-1:0] HDR_IDX      = 6'h00,
  parameter logic [IDX_W-1:0] PM_CTL_IDX   = 6'h10,
  parameter logic [IDX_W-1:0] PM_BASE_IDX  = 6'h12,
  parameter logic [IDX_W-1:0] SMB_BASE_IDX = 6'h24,
  parameter logic [IDX_W-1:0] SMB_CTL_IDX  = 6'h34,
  parameter logic [31:0]      HDR_WORD     = 32'hC0DE_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [IO_AW-1:0] io_addr,
  output logic             pm_hit,
  output logic             smb_hit
);

  localparam logic [31:0] IO_MASK  = (32'h1 << IO_AW) - 32'h1;
  localparam logic [31:0] PM_MASK  = IO_MASK & ~((32'h1 << PM_SPAN_LG) - 32'h1);
  localparam logic [31:0] SMB_MASK = IO_MASK & ~((32'h1 << SMB_SPAN_LG) - 32'h1);
  localparam logic [31:0] BASE_RST = 32'h1;

  logic [31:0]             pm_q, smb_q;
  logic [7:0]              pm_ctl_q;
  logic [SMB_CTL_KEEP-1:0] smb_ctl_q;
  logic [31:0]             lane_mask, pm_mrg, smb_mrg;
  logic                    wr_any;

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign lane_mask[8*l +: 8] = {8{cfg_be[l]}};
  end

  assign wr_any  = cfg_we && (cfg_be != 4'h0);
  assign pm_mrg  = (pm_q  & ~lane_mask) | (cfg_wdata & lane_mask);
  assign smb_mrg = (smb_q & ~lane_mask) | (cfg_wdata & lane_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pm_q      <= BASE_RST;
      smb_q     <= BASE_RST;
      pm_ctl_q  <= '0;
      smb_ctl_q <= '0;
    end else if (wr_any) begin
      if (cfg_idx == PM_BASE_IDX)  pm_q  <= (pm_mrg  & PM_MASK)  | BASE_RST;
      if (cfg_idx == SMB_BASE_IDX) smb_q <= (smb_mrg & SMB_MASK) | BASE_RST;
      if (cfg_idx == PM_CTL_IDX && cfg_be[PM_CTL_LANE])
        pm_ctl_q <= cfg_wdata[8*PM_CTL_LANE +: 8];
      if (cfg_idx == SMB_CTL_IDX && cfg_be[SMB_CTL_LANE])
        smb_ctl_q <= cfg_wdata[8*SMB_CTL_LANE +: SMB_CTL_KEEP];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx == HDR_IDX)      cfg_rdata = HDR_WORD;
    if (cfg_idx == PM_BASE_IDX)  cfg_rdata = pm_q;
    if (cfg_idx == SMB_BASE_IDX) cfg_rdata = smb_q;
    if (cfg_idx == PM_CTL_IDX)   cfg_rdata[8*PM_CTL_LANE +: 8] = pm_ctl_q;
    if (cfg_idx == SMB_CTL_IDX)  cfg_rdata[8*SMB_CTL_LANE +: SMB_CTL_KEEP] = smb_ctl_q;
  end

  assign pm_hit  = pm_ctl_q[PM_EN_BIT] &&
                   (io_addr[IO_AW-1:PM_SPAN_LG] == pm_q[IO_AW-1:PM_SPAN_LG]);
  assign smb_hit = smb_ctl_q[SMB_EN_BIT] &&
                   (io_addr[IO_AW-1:SMB_SPAN_LG] == smb_q[IO_AW-1:SMB_SPAN_LG]);

endmodule

// File: rtl/pm_iodec_chk.sv
module pm_iodec_chk #(
  parameter int IDX_W        = 6,
  parameter int IO_AW        = 16,
  parameter int PM_SPAN_LG   = 7,
  parameter int SMB_SPAN_LG  = 4,
  parameter int SMB_CTL_KEEP = 4,
  parameter logic [IDX_W-1:0] PM_BASE_IDX  = 6'h12,
  parameter logic [IDX_W-1:0] SMB_BASE_IDX = 6'h24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_we,
  input logic [IDX_W-1:0]        cfg_idx,
  input logic [3:0]              cfg_be,
  input logic [IO_AW-1:0]        io_addr,
  input logic                    pm_hit,
  input logic                    smb_hit,
  input logic [31:0]             pm_q,
  input logic [31:0]             smb_q,
  input logic [7:0]              pm_ctl_q,
  input logic [SMB_CTL_KEEP-1:0] smb_ctl_q
);

  p_reset_bases_r1: assert property (@(posedge clk)
    !rst_n |=> (pm_q == 32'h1 && smb_q == 32'h1 && pm_ctl_q == 8'h0 && smb_ctl_q == '0));

  p_hold_without_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(pm_q) && $stable(smb_q) && $stable(pm_ctl_q) && $stable(smb_ctl_q)));

  p_pm_base_format_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == PM_BASE_IDX && cfg_be != 4'h0) |=>
      (pm_q[0] && pm_q[PM_SPAN_LG-1:1] == '0 && pm_q[31:IO_AW] == '0));

  p_smb_base_format_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == SMB_BASE_IDX && cfg_be != 4'h0) |=>
      (smb_q[0] && smb_q[SMB_SPAN_LG-1:1] == '0 && smb_q[31:IO_AW] == '0));

  p_pm_hit_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pm_hit |-> (io_addr[IO_AW-1:PM_SPAN_LG] == pm_q[IO_AW-1:PM_SPAN_LG]));

  p_smb_hit_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smb_hit |-> (io_addr[IO_AW-1:SMB_SPAN_LG] == smb_q[IO_AW-1:SMB_SPAN_LG]));

  p_hit_change_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(pm_hit) || $changed(smb_hit)) |-> ($changed(io_addr) || $past(cfg_we)));

endmodule

bind pm_iodec pm_iodec_chk #(
  .IDX_W(IDX_W), .IO_AW(IO_AW), .PM_SPAN_LG(PM_SPAN_LG), .SMB_SPAN_LG(SMB_SPAN_LG),
  .SMB_CTL_KEEP(SMB_CTL_KEEP), .PM_BASE_IDX(PM_BASE_IDX), .SMB_BASE_IDX(SMB_BASE_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
  .io_addr(io_addr), .pm_hit(pm_hit), .smb_hit(smb_hit), .pm_q(pm_q), .smb_q(smb_q),
  .pm_ctl_q(pm_ctl_q), .smb_ctl_q(smb_ctl_q)
);

// File: tb/test_pm_iodec.sv
module test_pm_iodec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_pm, m_smb;
  logic [7:0]  m_c41, m_cd2;

  pm_iodec i_pm_iodec (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (be[l]) r[8*l +: 8] = d[8*l +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [5:0] idx);
    case (idx)
      6'h00: return 32'hC0DE_0100;
      6'h10: return {16'h0, m_c41, 8'h0};
      6'h12: return m_pm;
      6'h24: return m_smb;
      6'h34: return {8'h0, m_cd2, 16'h0};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic exp_pm_hit(logic [15:0] a);
    return m_c41[7] && (a[15:7] == m_pm[15:7]);
  endfunction

  function automatic logic exp_smb_hit(logic [15:0] a);
    return m_cd2[0] && (a[15:4] == m_smb[15:4]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (be != 4'h0) begin
      if (idx == 6'h12) m_pm  = (merge(m_pm,  d, be) & 32'h0000_FF80) | 32'h1;
      if (idx == 6'h24) m_smb = (merge(m_smb, d, be) & 32'h0000_FFF0) | 32'h1;
      if (idx == 6'h10 && be[1]) m_c41 = d[15:8];
      if (idx == 6'h34 && be[2]) m_cd2 = {4'h0, d[19:16]};
    end
  endtask

  task automatic rd(string req, logic [5:0] idx);
    cfg_idx = idx;
    #1;
    chk(req, cfg_rdata, exp_read(idx));
  endtask

  task automatic probe(string req, logic [15:0] a);
    io_addr = a;
    #1;
    chk(req, {31'h0, pm_hit},  {31'h0, exp_pm_hit(a)});
    chk(req, {31'h0, smb_hit}, {31'h0, exp_smb_hit(a)});
  endtask

  function automatic logic [5:0] pick_idx();
    case ($urandom % 7)
      0: return 6'h00;
      1: return 6'h10;
      2, 3: return 6'h12;
      4: return 6'h24;
      5: return 6'h34;
      default: return 6'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    m_pm = 32'h1; m_smb = 32'h1; m_c41 = '0; m_cd2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd("R1", 6'h12); rd("R1", 6'h24); rd("R1", 6'h10); rd("R1", 6'h34);
    probe("R1", 16'h0000);

    wr(6'h12, 4'hF, 32'hFFFF_FFFF); rd("R2", 6'h12);
    chk("R2", cfg_rdata, 32'h0000_FF81);
    wr(6'h24, 4'hF, 32'h1234_5678); rd("R3", 6'h24);
    chk("R3", cfg_rdata, 32'h0000_5671);
    wr(6'h12, 4'h1, 32'h0000_00C3); rd("R4", 6'h12);
    chk("R4", cfg_rdata, 32'h0000_FF81);
    wr(6'h12, 4'h2, 32'h0000_0400); rd("R4", 6'h12);
    chk("R4", cfg_rdata, 32'h0000_0481);
    wr(6'h12, 4'h0, 32'hFFFF_FFFF); rd("R4", 6'h12);

    wr(6'h10, 4'hF, 32'hFFFF_FFFF); rd("R5", 6'h10);
    chk("R9", cfg_rdata, 32'h0000_FF00);
    wr(6'h34, 4'hF, 32'hFFFF_FFFF); rd("R6", 6'h34);
    chk("R6", cfg_rdata, 32'h000F_0000);

    wr(6'h12, 4'h3, 32'h0000_0400);
    wr(6'h24, 4'h3, 32'h0000_0510);
    probe("R7", 16'h0400); probe("R7", 16'h047F);
    probe("R7", 16'h0480); probe("R7", 16'h03FF);
    probe("R8", 16'h0510); probe("R8", 16'h051F);
    probe("R8", 16'h0520); probe("R8", 16'h050F);
    wr(6'h10, 4'h2, 32'h0000_7F00); probe("R5", 16'h0400);
    wr(6'h34, 4'h4, 32'h00FE_0000); probe("R6", 16'h0510);
    rd("R6", 6'h34);

    wr(6'h00, 4'hF, 32'h0); rd("R10", 6'h00);
    wr(6'h3F, 4'hF, 32'hFFFF_FFFF); rd("R9", 6'h3F);
    wr(6'h13, 4'hF, 32'hFFFF_FFFF); rd("R9", 6'h13); rd("R9", 6'h12);

    for (int i = 0; i < 400; i++) begin
      logic [5:0]  idx = pick_idx();
      logic [3:0]  be  = 4'($urandom);
      logic [31:0] d   = $urandom;
      logic [15:0] base;
      logic [15:0] span;
      wr(idx, be, d);
      rd("R4", 6'h12); rd("R4", 6'h24); rd("R5", 6'h10); rd("R6", 6'h34);
      rd("R9", idx);
      for (int k = 0; k < 4; k++) begin
        if ($urandom % 2 == 0) begin base = m_pm[15:0] & 16'hFF80; span = 16'd128; end
        else begin base = m_smb[15:0] & 16'hFFF0; span = 16'd16; end
        case ($urandom % 5)
          0: probe("R7", base - 16'd1);
          1: probe("R8", base);
          2: probe("R7", base + span - 16'd1);
          3: probe("R8", base + span);
          default: probe("R7", base + 16'($urandom % span));
        endcase
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule